// File: doc/BRIEF.md
# Memory Pattern Test Engine

This engine decides whether a single read-capture delay setting works for a memory. When started, it walks a series of test windows across the memory. For each window it first drives the delay output to a fixed safe setting. It then writes every word of the window twice: first with a constant fill value, then with a pattern derived from the address. Next it switches the delay output to the candidate setting and reads the window back one word at a time, comparing each returned word with the pattern. The first mismatch stops the test with a fail result. If no mismatch occurs in any window, the result is a pass.

A calibration sequencer uses the engine as a probe. It runs the engine once per candidate delay and sweeps outwards from a known-good setting, choosing a different bias for each sweep direction. The bias and the candidate delay are captured when the test starts, so the caller may change them while a test is running.

Top module: `mem_pattern_tester`

## Requirements
- R1: After reset, `done`, `pass`, `memWe` and `memRe` are low and `dlyOut` holds the safe setting, which is coarse 7 and fine 4 in every lane. Each 8-bit lane keeps coarse in its upper nibble and fine in its lower nibble, so the default two-lane value is 16'h7474.
- R2: Window base byte offsets start at 0 and step by MEM_BYTES/64. A window is tested only when its base is strictly below MEM_BYTES minus the window size. A window is WIN_LINES × LINE_BYTES bytes long, so a passing run issues exactly (number of windows × words per window) reads.
- R3: Every word of a window is written with 32'h1f1f1f1f before it receives its pattern word. A window's fill pass completes before its pattern pass begins.
- R4: Every write is issued while `dlyOut` equals the safe setting.
- R5: Every read is issued while `dlyOut` equals the candidate that was captured at start.
- R6: The first read word that differs from its expected value ends the test. `done` then pulses with `pass` low, and no further read is issued.
- R7: When all windows match, `done` pulses for exactly one cycle with `pass` high. `pass` keeps its value until the next accepted start.
- R8: A `start` that arrives while a test is running is ignored. The running test keeps its captured candidate, its bias and its result.
- R9: At most one read is outstanding at a time. A new read is issued only after `memRvalid` has returned the previous one.
- R10: The pattern word equals the window base byte offset plus the word index plus the `bias` captured at start, computed modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a test; accepted only when idle |
| dlyCand | input | DLY_LANES*8 | Candidate delay setting under test |
| bias | input | DATA_W | Offset added to every pattern word |
| memAddr | output | ADDR_W | Byte address of the current word |
| memWdata | output | DATA_W | Write data |
| memWe | output | 1 | Write strobe, one word per cycle |
| memRe | output | 1 | Read request strobe |
| memRdata | input | DATA_W | Read data, valid with memRvalid |
| memRvalid | input | 1 | Read data valid strobe |
| dlyOut | output | DLY_LANES*8 | Delay setting driven to the read capture logic |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last test |

## Verification
The bound checker looks at every cycle. It checks that writes only happen under the safe delay and reads only under the captured candidate, that reads never overlap, that a read and a write are never issued together, that `done` is a single-cycle pulse, and that a `start` during a run leaves the engine busy. The bench scenarios cover the rest. They check the number of windows and reads, the final memory contents as a function of bias and window overlap, the ordering of fill and pattern writes, the exact read at which a fault stops the test, and that no read follows a failure.

// File: rtl/mte_pkg.sv
package mte_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_FILL, ST_PATT, ST_READ, ST_WAIT, ST_FINISH
  } mteState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCfg;    // capture candidate and bias
    logic clrOff;
    logic incOff;
    logic clrIdx;
    logic incIdx;
    logic dlySafe;  // load safe delay
    logic dlyCand;  // load captured candidate
    logic we;
    logic wrPat;    // select pattern instead of fill constant
    logic re;
  } mteCtl_t;

  localparam logic [31:0] FILL_WORD = 32'h1f1f1f1f;
  localparam logic [7:0]  SAFE_LANE = 8'h74; // coarse 7, fine 4

endpackage

// File: rtl/mte_ctrl.sv
module mte_ctrl
  import mte_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    winValid,
  input  logic    idxLast,
  input  logic    rvalid,
  input  logic    match,
  output mteCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    pass
);

  mteState_t state, stateNx;
  logic passReg, passNx;

  always_comb begin
    stateNx = state;
    passNx  = passReg;
    ctl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.ldCfg  = 1'b1;
          ctl.clrOff = 1'b1;
          ctl.clrIdx = 1'b1;
          passNx     = 1'b0;
          stateNx    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (winValid) begin
          ctl.dlySafe = 1'b1;
          stateNx     = ST_FILL;
        end else begin
          passNx  = 1'b1;
          stateNx = ST_FINISH;
        end
      end
      ST_FILL: begin
        ctl.we = 1'b1;
        if (idxLast) begin
          ctl.clrIdx = 1'b1;
          stateNx    = ST_PATT;
        end else begin
          ctl.incIdx = 1'b1;
        end
      end
      ST_PATT: begin
        ctl.we    = 1'b1;
        ctl.wrPat = 1'b1;
        if (idxLast) begin
          ctl.clrIdx  = 1'b1;
          ctl.dlyCand = 1'b1;
          stateNx     = ST_READ;
        end else begin
          ctl.incIdx = 1'b1;
        end
      end
      ST_READ: begin
        ctl.re  = 1'b1;
        stateNx = ST_WAIT;
      end
      ST_WAIT: begin
        if (rvalid) begin
          if (!match) begin
            passNx  = 1'b0;
            stateNx = ST_FINISH;
          end else if (idxLast) begin
            ctl.clrIdx = 1'b1;
            ctl.incOff = 1'b1;
            stateNx    = ST_CHECK;
          end else begin
            ctl.incIdx = 1'b1;
            stateNx    = ST_READ;
          end
        end
      end
      ST_FINISH: stateNx = ST_IDLE;
      default:   stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      passReg <= 1'b0;
    end else begin
      state   <= stateNx;
      passReg <= passNx;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FINISH);
  assign pass = passReg;

endmodule

// File: rtl/mte_dpath.sv
module mte_dpath
  import mte_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int MEM_BYTES  = 1 << 20,
  parameter int LINE_BYTES = 32,
  parameter int WIN_LINES  = 128,
  parameter int DLY_LANES  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mteCtl_t                ctl,
  input  logic [DLY_LANES*8-1:0] dlyCand,
  input  logic [DATA_W-1:0]      bias,
  input  logic [DATA_W-1:0]      memRdata,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic [DLY_LANES*8-1:0] dlyOut,
  output logic                   winValid,
  output logic                   idxLast,
  output logic                   match
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WB_SHIFT   = $clog2(WORD_BYTES);
  localparam int WIN_BYTES  = WIN_LINES * LINE_BYTES;
  localparam int WIN_WORDS  = WIN_BYTES / WORD_BYTES;
  localparam int IDX_W      = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
  localparam int STEP       = MEM_BYTES / 64;
  localparam int LIMIT      = (MEM_BYTES > WIN_BYTES) ? (MEM_BYTES - WIN_BYTES) : 0;
  localparam int OFF_W      = $clog2(MEM_BYTES) + 2;
  localparam int DLY_W      = DLY_LANES * 8;

  logic [DLY_W-1:0]  safeDly;
  logic [OFF_W-1:0]  offReg;
  logic [IDX_W-1:0]  idxReg;
  logic [DLY_W-1:0]  candReg;
  logic [DATA_W-1:0] biasReg;
  logic [DLY_W-1:0]  dlyReg;
  logic [DATA_W-1:0] pattern;

  for (genvar g = 0; g < DLY_LANES; g++) begin : gSafe
    assign safeDly[g*8 +: 8] = SAFE_LANE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg  <= '0;
      idxReg  <= '0;
      candReg <= '0;
      biasReg <= '0;
      dlyReg  <= safeDly;
    end else begin
      if (ctl.ldCfg) begin
        candReg <= dlyCand;
        biasReg <= bias;
      end
      if (ctl.clrOff)      offReg <= '0;
      else if (ctl.incOff) offReg <= offReg + OFF_W'(STEP);
      if (ctl.clrIdx)      idxReg <= '0;
      else if (ctl.incIdx) idxReg <= idxReg + 1'b1;
      if (ctl.dlySafe)      dlyReg <= safeDly;
      else if (ctl.dlyCand) dlyReg <= candReg;
    end
  end

  assign winValid = offReg < OFF_W'(LIMIT);
  assign idxLast  = idxReg == IDX_W'(WIN_WORDS - 1);
  assign pattern  = DATA_W'(offReg) + DATA_W'(idxReg) + biasReg;
  assign match    = memRdata == pattern;
  assign memAddr  = ADDR_W'(offReg) + (ADDR_W'(idxReg) << WB_SHIFT);
  assign memWdata = ctl.wrPat ? pattern : DATA_W'(FILL_WORD);
  assign dlyOut   = dlyReg;

endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester
  import mte_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 32,
  parameter int MEM_BYTES  = 1 << 20,
  parameter int LINE_BYTES = 32,
  parameter int WIN_LINES  = 128,
  parameter int DLY_LANES  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [DLY_LANES*8-1:0] dlyCand,
  input  logic [DATA_W-1:0]      bias,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata,
  output logic                   memWe,
  output logic                   memRe,
  input  logic [DATA_W-1:0]      memRdata,
  input  logic                   memRvalid,
  output logic [DLY_LANES*8-1:0] dlyOut,
  output logic                   done,
  output logic                   pass
);

  mteCtl_t ctl;
  logic winValid, idxLast, match, busy;

  mte_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .winValid(winValid),
    .idxLast(idxLast), .rvalid(memRvalid), .match(match),
    .ctl(ctl), .busy(busy), .done(done), .pass(pass)
  );

  mte_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES),
    .LINE_BYTES(LINE_BYTES), .WIN_LINES(WIN_LINES), .DLY_LANES(DLY_LANES)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dlyCand(dlyCand), .bias(bias),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .dlyOut(dlyOut), .winValid(winValid), .idxLast(idxLast), .match(match)
  );

  assign memWe = ctl.we;
  assign memRe = ctl.re;

endmodule

// File: rtl/mte_checker.sv
module mte_checker #(
  parameter int DLY_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             memWe,
  input logic             memRe,
  input logic             memRvalid,
  input logic             done,
  input logic [DLY_W-1:0] dlyOut,
  input logic [DLY_W-1:0] dlyCand
);

  logic pend;
  logic [DLY_W-1:0] capCand;
  logic [DLY_W-1:0] safeDly;

  always_comb begin
    for (int i = 0; i < DLY_W / 8; i++) safeDly[i*8 +: 8] = 8'h74;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend    <= 1'b0;
      capCand <= '0;
    end else begin
      if (memRe)          pend <= 1'b1;
      else if (memRvalid) pend <= 1'b0;
      if (start && !busy) capCand <= dlyCand;
    end
  end

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> !pend);
  a_r4_write_safe_dly: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> dlyOut == safeDly);
  a_r5_read_cand_dly: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> dlyOut == capCand);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r3_no_rw_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && !done) |=> busy);

endmodule

bind mem_pattern_tester mte_checker #(.DLY_W(DLY_LANES*8)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .memWe(memWe),
  .memRe(memRe), .memRvalid(memRvalid), .done(done), .dlyOut(dlyOut),
  .dlyCand(dlyCand)
);

// File: tb/sim_mem_pattern_tester.sv
`timescale 1ns/1ps
module sim_mem_pattern_tester;

  localparam int MEM   = 1024;
  localparam int LINEB = 4;
  localparam int WLN   = 16;
  localparam int WINB  = WLN * LINEB;   // 64 bytes
  localparam int WINW  = WINB / 4;      // 16 words
  localparam int STEPB = MEM / 64;      // 16 bytes
  localparam int NW    = MEM / 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dlyCand = '0;
  logic [31:0] bias = '0;
  logic [9:0]  memAddr;
  logic [31:0] memWdata;
  logic        memWe, memRe;
  logic [31:0] memRdata;
  logic        memRvalid;
  logic [15:0] dlyOut;
  logic        done, pass;

  always #4 clk = ~clk;

  mem_pattern_tester #(
    .ADDR_W(10), .DATA_W(32), .MEM_BYTES(MEM), .LINE_BYTES(LINEB),
    .WIN_LINES(WLN), .DLY_LANES(2)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .dlyCand(dlyCand), .bias(bias),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .memRvalid(memRvalid), .dlyOut(dlyOut),
    .done(done), .pass(pass)
  );

  // memory model with fault injection
  logic [31:0] mem [NW];
  logic        filled [NW];
  logic        clrCnt = 1'b0;
  logic        faultEn = 1'b0;
  logic [9:0]  faultAddr = '0;
  logic [15:0] expCand = '0;
  int rdCnt, fillCnt, badWrDly, badRdDly, orderErr, ovlErr;
  logic pendTb;

  always_ff @(posedge clk) begin
    memRvalid <= 1'b0;
    if (clrCnt) begin
      rdCnt <= 0; fillCnt <= 0; badWrDly <= 0; badRdDly <= 0;
      orderErr <= 0; ovlErr <= 0; pendTb <= 1'b0;
    end else begin
      if (memRvalid) pendTb <= 1'b0;
      if (memWe) begin
        mem[memAddr[9:2]] <= memWdata;
        if (dlyOut != 16'h7474) badWrDly <= badWrDly + 1;
        if (memWdata == 32'h1f1f1f1f) begin
          filled[memAddr[9:2]] <= 1'b1;
          fillCnt <= fillCnt + 1;
        end else begin
          if (!filled[memAddr[9:2]]) orderErr <= orderErr + 1;
          filled[memAddr[9:2]] <= 1'b0;
        end
      end
      if (memRe) begin
        rdCnt <= rdCnt + 1;
        if (pendTb) ovlErr <= ovlErr + 1;
        pendTb <= 1'b1;
        if (dlyOut != expCand) badRdDly <= badRdDly + 1;
        memRvalid <= 1'b1;
        memRdata <= mem[memAddr[9:2]]
                    ^ ((faultEn && memAddr == faultAddr) ? 32'h1 : 32'h0)
                    ^ ((dlyOut[7:4] > 4'hB) ? 32'h100 : 32'h0);
      end
    end
  end

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int numWin();
    int n = 0;
    for (int k = 0; k < 64; k++) if (k * STEPB < MEM - WINB) n++;
    return n;
  endfunction

  typedef struct packed {
    logic [15:0] cand;
    logic [31:0] bias;
    logic        fEn;
    logic [9:0]  fAddr;
    logic        expPass;
    logic [15:0] expReads;
  } vec_t;

  // fault at byte 200: first seen in window 9 (bytes 144..207), word 14 -> 9*16+15 reads
  localparam vec_t VECS [5] = '{
    '{16'h7474, 32'd3, 1'b0, 10'd0,   1'b1, 16'd960},
    '{16'h5a3c, 32'd1, 1'b0, 10'd0,   1'b1, 16'd960},
    '{16'h00c4, 32'd3, 1'b0, 10'd0,   1'b0, 16'd1},
    '{16'h9999, 32'd1, 1'b1, 10'd200, 1'b0, 16'd159},
    '{16'h9999, 32'd3, 1'b1, 10'd0,   1'b0, 16'd1}
  };

  task automatic pulseStart(input logic [15:0] c, input logic [31:0] b);
    @(negedge clk);
    dlyCand = c; bias = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic clearCounters();
    @(negedge clk); clrCnt = 1'b1;
    @(negedge clk); clrCnt = 1'b0;
  endtask

  // waits for done sampled at negedge; returns pass
  task automatic waitDone(output bit gotPass, output bit ok);
    int t = 0;
    ok = 1'b0; gotPass = 1'b0;
    while (t < 20000) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; gotPass = pass; break; end
      t++;
    end
  endtask

  task automatic checkMemory(input logic [31:0] b, input string req);
    int bad = 0;
    longint firstAct = 0, firstExp = 0;
    for (int w = 0; w < NW; w++) begin
      int by = w * 4;
      int k;
      logic [31:0] e;
      if (by >= (numWin() - 1) * STEPB + WINB) continue;
      k = by / STEPB;
      if (k > numWin() - 1) k = numWin() - 1;
      e = 32'(k * STEPB + (by - k * STEPB) / 4) + b;
      if (mem[w] !== e) begin
        if (bad == 0) begin firstAct = mem[w]; firstExp = e; end
        bad++;
      end
    end
    chk(bad == 0, req, firstAct, firstExp);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin mem[w] = '0; filled[w] = 1'b0; end
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(done == 1'b0 && pass == 1'b0, "R1 done/pass", {done, pass}, 0);
    chk(memWe == 1'b0 && memRe == 1'b0, "R1 strobes", {memWe, memRe}, 0);
    chk(dlyOut == 16'h7474, "R1 safe delay", dlyOut, 16'h7474);
    rstN = 1'b1;

    foreach (VECS[i]) begin
      bit gp, ok;
      faultEn = VECS[i].fEn; faultAddr = VECS[i].fAddr; expCand = VECS[i].cand;
      clearCounters();
      pulseStart(VECS[i].cand, VECS[i].bias);
      waitDone(gp, ok);
      chk(ok, "R7 done seen", ok, 1);
      chk(gp == VECS[i].expPass, VECS[i].expPass ? "R7 pass result" : "R6 fail result",
          gp, VECS[i].expPass);
      @(negedge clk);
      chk(done == 1'b0, "R7 done one cycle", done, 0);
      chk(pass == VECS[i].expPass, "R7 pass held", pass, VECS[i].expPass);
      repeat (20) @(negedge clk);
      // R6 no extra reads after fail; R2 read count on pass
      chk(rdCnt == int'(VECS[i].expReads), VECS[i].expPass ? "R2 read count" : "R6 stop reads",
          rdCnt, VECS[i].expReads);
      chk(badWrDly == 0, "R4 write delay", badWrDly, 0);
      chk(badRdDly == 0, "R5 read delay", badRdDly, 0);
      chk(orderErr == 0, "R3 fill before pattern", orderErr, 0);
      chk(ovlErr == 0, "R9 overlap", ovlErr, 0);
      if (VECS[i].expPass) begin
        chk(fillCnt == numWin() * WINW, "R3 fill count", fillCnt, numWin() * WINW);
        checkMemory(VECS[i].bias, "R10 R2 memory pattern");
      end
    end

    // R8: start during a run is ignored
    begin
      bit gp, ok;
      faultEn = 1'b0; expCand = 16'h6363;
      clearCounters();
      pulseStart(16'h6363, 32'd3);
      repeat (100) @(negedge clk);
      pulseStart(16'h00c4, 32'd1);
      waitDone(gp, ok);
      chk(ok && gp, "R8 result kept", gp, 1);
      repeat (5) @(negedge clk);
      chk(rdCnt == numWin() * WINW, "R8 read count", rdCnt, numWin() * WINW);
      chk(badRdDly == 0, "R8 candidate kept", badRdDly, 0);
      checkMemory(32'd3, "R8 R10 bias kept");
    end

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule